// File: doc/BRIEF.md
# Page-Mode Parallel Memory Read Front-End

This block is a clocked model of the read side of a parallel memory that offers fast page reads. Each clock it samples an active-low chip enable, an active-low output enable, a byte/word mode select and an address bus. A page is four 16-bit words, which is eight bytes. The word address bits above the lowest two form the page index. The block remembers the page of the last access. A read that opens a different page waits the full random-access latency. A read inside the page that is already open waits only the shorter page latency.

A valid strobe rises when the access is complete and the outputs are enabled. Read data appears on the data bus in the same cycle. A separate drive flag says when the bus would be actively driven. When that flag is low, the bus stands for high impedance. In byte mode, one extra least-significant address bit picks a byte lane, and the byte is returned on the low eight data bits. The storage behind the front-end is an internal register file. Its contents are a fixed function of the word address.

Top module: `pmr_read_front`

## Requirements
- R1: While chip_en_ni is high, valid_o, drive_o and data_o are all 0. This includes the state right after reset.
- R2: The first access after reset is timed from the clock edge that samples its address, called edge 1. So is an access to a page other than the open one. valid_o goes high just after edge RAND_LAT and not earlier.
- R3: An access to another word of the open page goes valid just after edge PAGE_LAT, counted the same way.
- R4: In word mode (byte_mode_i = 0), the word address is addr_i[ADDR_W-1:0] and data_o carries the full 16-bit word. The page index is word address bits ADDR_W-1 down to 2. addr_i[ADDR_W] has no effect.
- R5: In byte mode (byte_mode_i = 1), the word address is addr_i[ADDR_W:1] and addr_i[0] picks the lane. Lane 0 returns bits 7:0 of the word and lane 1 returns bits 15:8. The byte appears on data_o[7:0], and data_o[15:8] is 0.
- R6: Word w of the store holds the value {(w XOR 8'hA5) mod 256, (3*w + 1) mod 256}, with the high byte first.
- R7: drive_o is high exactly when chip_en_ni and out_en_ni are both low. A high out_en_ni forces valid_o low but does not stop the access. If out_en_ni falls after the latency has run out, valid_o rises in that same cycle.
- R8: A high chip_en_ni that is sampled on a clock edge closes the open page. The next access then takes RAND_LAT even if it uses the same page.
- R9: A change of the effective address or of the mode restarts the access, whether the old access was pending or complete. The restart is timed as a fresh access. It uses PAGE_LAT if the new page equals the open page and RAND_LAT otherwise. valid_o is low from the cycle in which the change appears.
- R10: data_o is 0 whenever valid_o is low. While valid_o stays high, data_o is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_en_ni | input | 1 | Chip enable, active low |
| out_en_ni | input | 1 | Output enable, active low |
| byte_mode_i | input | 1 | 1 selects byte mode, 0 selects word mode |
| addr_i | input | ADDR_W+1 | Address; the LSB is the lane select in byte mode |
| data_o | output | 16 | Read data, 0 when not valid |
| valid_o | output | 1 | Access complete and outputs enabled |
| drive_o | output | 1 | Bus driven; low stands for high impedance |

## Verification
The bench builds the block with ADDR_W = 6, RAND_LAT = 5 and PAGE_LAT = 3. The two latencies are close but distinct, so a wrong hit or miss decision shows up as a one- or two-cycle error. A restart two cycles into a five-cycle access lands while that access is still pending. The small store keeps addresses in different pages easy to choose, and every byte pattern can still be told apart.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam int unsigned PAGE_WORDS_LG = 2;

  function automatic logic [WORD_W-1:0] store_pattern(input int unsigned w);
    logic [BYTE_W-1:0] lo, hi;
    lo = BYTE_W'((w * 3 + 1) % 256);
    hi = BYTE_W'((w ^ 32'hA5) % 256);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/pmr_page_track.sv
module pmr_page_track #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             hit_o
);
  logic [IDX_W-1:0] page_q;
  logic             open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      open_q <= 1'b0;
    end else if (clear_i) begin
      open_q <= 1'b0;
    end else if (load_i) begin
      page_q <= idx_i;
      open_q <= 1'b1;
    end
  end

  assign hit_o = open_q && (page_q == idx_i);
endmodule

// File: rtl/pmr_lat_count.sv
module pmr_lat_count #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      armed_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = armed_q && (cnt_q == '0);
endmodule

// File: rtl/pmr_word_store.sv
module pmr_word_store
  import pmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] word_addr_i,
  input  logic              lane_i,
  input  logic              byte_mode_i,
  output logic [WORD_W-1:0] data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] words [DEPTH];
  logic [WORD_W-1:0] word_sel;

  // register file, loaded with its fixed pattern at reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) words[g] <= store_pattern(g);
      else         words[g] <= words[g];
    end
  end

  assign word_sel = words[word_addr_i];

  always_comb begin
    if (!byte_mode_i)  data_o = word_sel;
    else if (lane_i)   data_o = {{BYTE_W{1'b0}}, word_sel[WORD_W-1:BYTE_W]};
    else               data_o = {{BYTE_W{1'b0}}, word_sel[BYTE_W-1:0]};
  end
endmodule

// File: rtl/pmr_read_front.sv
module pmr_read_front
  import pmr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned RAND_LAT = 7,
  parameter int unsigned PAGE_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_en_ni,
  input  logic              out_en_ni,
  input  logic              byte_mode_i,
  input  logic [ADDR_W:0]   addr_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              drive_o
);
  localparam int unsigned MAX_LAT = (RAND_LAT > PAGE_LAT) ? RAND_LAT : PAGE_LAT;
  localparam int unsigned CNT_W   = (MAX_LAT < 2) ? 1 : $clog2(MAX_LAT);
  localparam int unsigned IDX_W   = ADDR_W - PAGE_WORDS_LG;
  localparam logic [CNT_W-1:0] RAND_LD = CNT_W'(RAND_LAT - 1);
  localparam logic [CNT_W-1:0] PAGE_LD = CNT_W'(PAGE_LAT - 1);

  logic              sel, out_on, chg, hit, done;
  logic [ADDR_W:0]   eff_addr, addr_q;
  logic              mode_q, active_q;
  logic [ADDR_W-1:0] word_addr, word_addr_q;
  logic [WORD_W-1:0] store_data;

  assign sel    = !chip_en_ni;
  assign out_on = sel && !out_en_ni;

  // word mode ignores the top address bit
  assign eff_addr  = byte_mode_i ? addr_i : {1'b0, addr_i[ADDR_W-1:0]};
  assign word_addr = byte_mode_i ? addr_i[ADDR_W:1] : addr_i[ADDR_W-1:0];
  assign chg = sel && (!active_q || (eff_addr != addr_q) || (byte_mode_i != mode_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      mode_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      active_q <= sel;
      if (chg) begin
        addr_q <= eff_addr;
        mode_q <= byte_mode_i;
      end
    end
  end

  pmr_page_track #(.IDX_W(IDX_W)) u_page (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(!sel),
    .load_i (chg),
    .idx_i  (word_addr[ADDR_W-1:PAGE_WORDS_LG]),
    .hit_o  (hit)
  );

  pmr_lat_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (!sel),
    .load_i    (chg),
    .load_val_i(hit ? PAGE_LD : RAND_LD),
    .done_o    (done)
  );

  assign word_addr_q = mode_q ? addr_q[ADDR_W:1] : addr_q[ADDR_W-1:0];

  pmr_word_store #(.ADDR_W(ADDR_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_addr_i(word_addr_q),
    .lane_i     (addr_q[0]),
    .byte_mode_i(mode_q),
    .data_o     (store_data)
  );

  assign drive_o = out_on;
  assign valid_o = out_on && !chg && done;
  assign data_o  = valid_o ? store_data : '0;
endmodule

// File: rtl/pmr_read_front_chk.sv
module pmr_read_front_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              chip_en_ni,
  input logic              out_en_ni,
  input logic              byte_mode_i,
  input logic [ADDR_W:0]   addr_i,
  input logic [15:0]       data_o,
  input logic              valid_o,
  input logic              drive_o
);
  logic [ADDR_W:0] eff;
  assign eff = byte_mode_i ? addr_i : {1'b0, addr_i[ADDR_W-1:0]};

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_en_ni |-> (!valid_o && !drive_o && data_o == '0));

  assert_oe_gates_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_ni |-> (!drive_o && !valid_o));

  assert_reselect_slow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(chip_en_ni) |-> !valid_o);

  assert_change_restarts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chip_en_ni && !$past(chip_en_ni) &&
     (eff != $past(eff) || byte_mode_i != $past(byte_mode_i))) |-> !valid_o);

  assert_zero_when_invalid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> data_o == '0);

  assert_stable_data_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> $stable(data_o));
endmodule

bind pmr_read_front pmr_read_front_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_pmr_read_front.sv
module sim_pmr_read_front;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int RL = 5;
  localparam int PL = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          chip_en_ni = 1'b1;
  logic          out_en_ni = 1'b0;
  logic          byte_mode_i = 1'b0;
  logic [AW:0]   addr_i = '0;
  logic [15:0]   data_o;
  logic          valid_o, drive_o;

  int checks = 0;
  int errors = 0;

  pmr_read_front #(.ADDR_W(AW), .RAND_LAT(RL), .PAGE_LAT(PL)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [15:0] exp_word(input int w);
    logic [7:0] lo, hi;
    lo = 8'((w * 3 + 1) % 256);
    hi = 8'((w ^ 'hA5) % 256);
    return {hi, lo};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // caller sits just after a negedge; drives and counts edges until valid
  task automatic access(input string req, input logic mode, input logic [AW:0] a,
                        input int exp_lat, input logic [15:0] exp_d);
    int n;
    byte_mode_i = mode;
    addr_i = a;
    chip_en_ni = 1'b0;
    n = 0;
    do begin
      @(posedge clk_i); n++; @(negedge clk_i);
    end while (!valid_o && n < 40);
    chk({req, " latency"}, n, exp_lat);
    chk({req, " data"}, data_o, exp_d);
    chk({req, " drive"}, drive_o, 1'b1);
  endtask

  task automatic t_reset_idle;
    chk("R1 valid idle", valid_o, 0);
    chk("R1 drive idle", drive_o, 0);
    chk("R1 data idle", data_o, 0);
  endtask

  task automatic t_word_page;
    access("R2 R6 first", 1'b0, 7'd9, RL, exp_word(9));
    access("R3 R4 same page", 1'b0, 7'd11, PL, exp_word(11));
    access("R3 same page back", 1'b0, 7'd8, PL, exp_word(8));
    access("R2 new page", 1'b0, 7'd20, RL, exp_word(20));
  endtask

  task automatic t_ignored_top_bit;
    addr_i = 7'd20 | 7'h40;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      chk("R4 top bit ignored valid", valid_o, 1);
      chk("R4 top bit ignored data", data_o, exp_word(20));
    end
  endtask

  task automatic t_byte_mode;
    access("R9 R5 mode change same page lane0", 1'b1, 7'd40, PL, {8'h00, exp_word(20)}[15:0] & 16'h00FF);
    access("R5 lane1", 1'b1, 7'd41, PL, {8'h00, exp_word(20)[15:8]});
    access("R5 R2 byte new page", 1'b1, 7'd101, RL, {8'h00, exp_word(50)[15:8]});
  endtask

  task automatic t_out_enable;
    out_en_ni = 1'b1;
    byte_mode_i = 1'b0;
    addr_i = 7'd60;
    for (int i = 0; i < RL + 2; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      chk("R7 oe high valid", valid_o, 0);
      chk("R7 oe high drive", drive_o, 0);
      chk("R10 oe high data", data_o, 0);
    end
    out_en_ni = 1'b0;
    #1;
    chk("R7 oe low immediate valid", valid_o, 1);
    chk("R7 oe low data", data_o, exp_word(60));
    chk("R7 oe low drive", drive_o, 1);
  endtask

  task automatic t_deselect;
    @(negedge clk_i);
    chip_en_ni = 1'b1;
    #1;
    chk("R1 deselect valid", valid_o, 0);
    chk("R1 deselect drive", drive_o, 0);
    @(posedge clk_i); @(negedge clk_i);
    access("R8 reselect same page", 1'b0, 7'd61, RL, exp_word(61));
  endtask

  task automatic t_restart;
    byte_mode_i = 1'b0;
    addr_i = 7'd4;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      chk("R9 pending no valid", valid_o, 0);
    end
    access("R9 restart same page", 1'b0, 7'd6, PL, exp_word(6));
    addr_i = 7'd32;
    #1;
    chk("R9 change drops valid", valid_o, 0);
    chk("R10 change zero data", data_o, 0);
    access("R9 restart new page", 1'b0, 7'd32, RL, exp_word(32));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_idle();
    t_word_page();
    t_ignored_top_bit();
    t_byte_mode();
    t_out_enable();
    t_deselect();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule